// File: doc/BRIEF.md
# Vector Byte Extract Unit

This block decodes and executes a single vector extract instruction against a vector register file that it owns. Each accepted instruction word names a destination register, two source registers, a width bit and a four-bit byte offset. The two sources are placed side by side, the second above the first, to form a value of twice the operand width. A window of the operand width is then taken from that value, starting at the byte offset. The low bytes of the result come from the top of the first source and the high bytes from the bottom of the second source. The window is written back to the destination register.

A 64-bit form with an offset of 8 or more is rejected: the block raises an undefined flag and leaves the register file untouched. A word whose fixed opcode bits do not match is ignored, with no write and no flag. A test write port preloads registers and a combinational test read port observes them.

The control path is a three-state machine. ST_IDLE means no instruction finished in the previous cycle. ST_DONE means a legal instruction was written back in the previous cycle, and the done output is high. ST_UNDEF means an illegal encoding was seen in the previous cycle, and the undef output is high. Transitions are taken from every state alike. The ACCEPT_OK transition, a valid matching legal word, leads to ST_DONE. The ACCEPT_BAD transition, a valid matching word in 64-bit form with offset bit 3 set, leads to ST_UNDEF. The QUIET transition, for no valid strobe or a non-matching word, leads to ST_IDLE.

Top module: `vext_unit`

## Requirements
- R1: The instruction word carries the destination in bits 4:0, the first source in 9:5, the offset in 14:11, the second source in 20:16 and the width bit in bit 30. It matches only when (word & 32'hBFE08400) == 32'h2E000000. A non-matching word writes nothing and raises neither done nor undef.
- R2: With bit 30 = 1, the destination receives bytes k..k+15 of the 32-byte value {second source, first source}, where k is the offset and byte 0 is the least significant byte of the first source.
- R3: With bit 30 = 0 and offset below 8, destination bits 63:0 receive bytes k..k+7 of {second[63:0], first[63:0]} and destination bits 127:64 are written as zero.
- R4: An offset of 0 returns the first source unchanged (its low 64 bits, zero-extended, in the 64-bit form).
- R5: With bit 30 = 0 and offset bit 3 = 1, undef is high for exactly the cycle after acceptance and no register changes.
- R6: done is high for exactly the cycle after a legal instruction is accepted, and done and undef are never high together.
- R7: A synchronous reset clears all 32 registers to zero and drives done and undef low.
- R8: The test write port writes tw_data into register tw_idx at the clock edge. rd_data shows register rd_idx combinationally.
- R9: Source registers are read before the write of the same cycle, so a destination equal to a source uses the old contents. An instruction in the following cycle sees the new value.
- R10: When the test write and an instruction target the same register in the same cycle, the instruction result is kept.
- R11: An instruction is accepted on every cycle that instr_valid is high, with no idle cycle needed between instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| tw_en | input | 1 | Test write enable |
| tw_idx | input | 5 | Test write register number |
| tw_data | input | 128 | Test write data |
| rd_idx | input | 5 | Test read register number |
| rd_data | output | 128 | Test read data, combinational |
| done | output | 1 | Legal instruction completed in previous cycle |
| undef | output | 1 | Illegal encoding seen in previous cycle |

## Verification
The assertions assume that reset is held high through the first clock edge, so that no $past term samples a register file that has not been cleared. The no-write and upper-zero checks also assume that rd_idx is held steady across the write edge and that the test write port is idle in that cycle. The bench drives every input at the falling edge and holds rd_idx between accesses. It never mixes a test write with an illegal or 64-bit instruction, except in the one collision scenario, which uses a legal 128-bit word.

// File: rtl/vext_pkg.sv
package vext_pkg;

    localparam int VLEN_DEF = 128;
    localparam int NREG_DEF = 32;
    localparam int INSN_W   = 32;
    localparam int RIDX_W   = 5;
    localparam int OFS_W    = 4;

    // fixed opcode bits of the extract form
    localparam logic [INSN_W-1:0] EXT_BASE = 32'h2E00_0000;
    localparam logic [INSN_W-1:0] EXT_MASK = 32'hBFE0_8400;

    localparam int DST_LSB  = 0;
    localparam int SRCA_LSB = 5;
    localparam int OFS_LSB  = 11;
    localparam int SRCB_LSB = 16;
    localparam int WIDE_BIT = 30;

    typedef struct packed {
        logic              wide;
        logic [RIDX_W-1:0] srcb;
        logic [OFS_W-1:0]  ofs;
        logic [RIDX_W-1:0] srca;
        logic [RIDX_W-1:0] dst;
    } vext_fields_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_UNDEF
    } vext_state_e;

endpackage

// File: rtl/vext_decode.sv
module vext_decode
    import vext_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output vext_fields_t      fields_o,
    output logic              is_ext_o,
    output logic              is_undef_o
);

    always_comb begin
        fields_o.dst  = word_i[DST_LSB  +: RIDX_W];
        fields_o.srca = word_i[SRCA_LSB +: RIDX_W];
        fields_o.ofs  = word_i[OFS_LSB  +: OFS_W];
        fields_o.srcb = word_i[SRCB_LSB +: RIDX_W];
        fields_o.wide = word_i[WIDE_BIT];
    end

    assign is_ext_o   = ((word_i & EXT_MASK) == EXT_BASE);
    assign is_undef_o = is_ext_o && !fields_o.wide && fields_o.ofs[OFS_W-1];

endmodule

// File: rtl/vext_regfile.sv
module vext_regfile #(
    parameter  int W   = 128,
    parameter  int N   = 32,
    parameter  int NRP = 3,
    localparam int AW  = $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tw_en_i,
    input  logic [AW-1:0]           tw_addr_i,
    input  logic [W-1:0]            tw_data_i,
    input  logic                    ex_en_i,
    input  logic [AW-1:0]           ex_addr_i,
    input  logic [W-1:0]            ex_data_i,
    input  logic [NRP-1:0][AW-1:0]  raddr_i,
    output logic [NRP-1:0][W-1:0]   rdata_o
);

    logic [W-1:0] mem_q [N];

    // execution write is issued last so it wins a same-register collision
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else begin
            if (tw_en_i) mem_q[tw_addr_i] <= tw_data_i;
            if (ex_en_i) mem_q[ex_addr_i] <= ex_data_i;
        end
    end

    for (genvar p = 0; p < NRP; p++) begin : g_rport
        assign rdata_o[p] = mem_q[raddr_i[p]];
    end

endmodule

// File: rtl/vext_window.sv
module vext_window #(
    parameter  int W  = 128,
    localparam int NB = W / 8,
    localparam int IW = $clog2(NB)
) (
    input  logic [W-1:0]  lo_i,
    input  logic [W-1:0]  hi_i,
    input  logic [IW-1:0] ofs_i,
    output logic [W-1:0]  win_o
);

    logic [2*NB-1:0][7:0] joined;
    assign joined = {hi_i, lo_i};

    for (genvar b = 0; b < NB; b++) begin : g_byte
        logic [IW:0] sel;
        assign sel = (IW+1)'(b) + {1'b0, ofs_i};
        assign win_o[8*b +: 8] = joined[sel];
    end

endmodule

// File: rtl/vext_unit.sv
module vext_unit
    import vext_pkg::*;
#(
    parameter  int VLEN = VLEN_DEF,
    parameter  int NREG = NREG_DEF,
    localparam int AW   = $clog2(NREG),
    localparam int HALF = VLEN / 2,
    localparam int IWH  = $clog2(HALF / 8),
    localparam int IWF  = $clog2(VLEN / 8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [INSN_W-1:0] instr_word,
    input  logic              tw_en,
    input  logic [AW-1:0]     tw_idx,
    input  logic [VLEN-1:0]   tw_data,
    input  logic [AW-1:0]     rd_idx,
    output logic [VLEN-1:0]   rd_data,
    output logic              done,
    output logic              undef
);

    vext_fields_t f;
    logic         is_ext, is_undef;

    vext_decode u_dec (
        .word_i    (instr_word),
        .fields_o  (f),
        .is_ext_o  (is_ext),
        .is_undef_o(is_undef)
    );

    logic [2:0][AW-1:0]   raddr;
    logic [2:0][VLEN-1:0] rdata;
    logic                 wr_en;
    logic [VLEN-1:0]      wr_data;

    assign raddr = {f.srcb, f.srca, rd_idx};

    vext_regfile #(.W(VLEN), .N(NREG), .NRP(3)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .tw_en_i  (tw_en),
        .tw_addr_i(tw_idx),
        .tw_data_i(tw_data),
        .ex_en_i  (wr_en),
        .ex_addr_i(f.dst),
        .ex_data_i(wr_data),
        .raddr_i  (raddr),
        .rdata_o  (rdata)
    );

    assign rd_data = rdata[0];

    logic [VLEN-1:0] win_full;
    logic [HALF-1:0] win_half;

    vext_window #(.W(VLEN)) u_win_full (
        .lo_i (rdata[1]),
        .hi_i (rdata[2]),
        .ofs_i(f.ofs[IWF-1:0]),
        .win_o(win_full)
    );

    vext_window #(.W(HALF)) u_win_half (
        .lo_i (rdata[1][HALF-1:0]),
        .hi_i (rdata[2][HALF-1:0]),
        .ofs_i(f.ofs[IWH-1:0]),
        .win_o(win_half)
    );

    assign wr_data = f.wide ? win_full : {{HALF{1'b0}}, win_half};
    assign wr_en   = instr_valid && is_ext && !is_undef;

    // state machine: every state takes the same three transitions
    vext_state_e state_q, state_d, accept_state;

    always_comb begin
        if (instr_valid && is_ext) accept_state = is_undef ? ST_UNDEF : ST_DONE;
        else                       accept_state = ST_IDLE;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:  state_d = accept_state;
            ST_DONE:  state_d = accept_state;
            ST_UNDEF: state_d = accept_state;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        done  = 1'b0;
        undef = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_DONE:  done  = 1'b1;
            ST_UNDEF: undef = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/vext_unit_chk.sv
module vext_unit_chk
    import vext_pkg::*;
#(
    parameter int VLEN = VLEN_DEF,
    parameter int AW   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [INSN_W-1:0] instr_word,
    input logic              tw_en,
    input logic [AW-1:0]     rd_idx,
    input logic [VLEN-1:0]   rd_data,
    input logic              done,
    input logic              undef
);

    logic hit, bad, good, narrow_ok;
    assign hit       = instr_valid && ((instr_word & EXT_MASK) == EXT_BASE);
    assign bad       = hit && !instr_word[WIDE_BIT] && instr_word[OFS_LSB+3];
    assign good      = hit && !bad;
    assign narrow_ok = good && !instr_word[WIDE_BIT];

    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && undef));                                               // R6

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(good));                                           // R6

    AST_UNDEF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        undef |-> $past(bad));                                           // R5

    AST_NOMATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(!hit) |-> !done && !undef);                                // R1

    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($past(bad && !tw_en) && rd_idx == $past(rd_idx)) |-> rd_data == $past(rd_data)); // R5

    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(narrow_ok && !tw_en) && rd_idx == $past(instr_word[AW-1:0]))
            |-> rd_data[VLEN-1:VLEN/2] == '0);                           // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> rd_data == '0 && !done && !undef);                // R7

endmodule

bind vext_unit vext_unit_chk #(.VLEN(VLEN), .AW(AW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .instr_valid(instr_valid),
    .instr_word (instr_word),
    .tw_en      (tw_en),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .done       (done),
    .undef      (undef)
);

// File: tb/vext_unit_tb_top.sv
module vext_unit_tb_top;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr_word = '0;
    logic         tw_en = 1'b0;
    logic [4:0]   tw_idx = '0;
    logic [127:0] tw_data = '0;
    logic [4:0]   rd_idx = '0;
    logic [127:0] rd_data;
    logic         done, undef;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    vext_unit dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
        .rd_idx(rd_idx), .rd_data(rd_data), .done(done), .undef(undef)
    );

    function automatic logic [31:0] mk(input bit q, input int rm, input int ofs,
                                       input int rn, input int rd);
        return 32'h2E00_0000 | (32'(q) << 30) | (32'(rm) << 16) | (32'(ofs) << 11)
             | (32'(rn) << 5) | 32'(rd);
    endfunction

    function automatic logic [127:0] pat(input int k);
        logic [127:0] v;
        for (int b = 0; b < 16; b++) v[8*b +: 8] = 8'((k * 16 + b) ^ 8'h5A);
        return v;
    endfunction

    function automatic logic [127:0] model(input bit q, input int ofs,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [255:0] j;
        logic [127:0] j64;
        if (q) begin
            j = {b, a} >> (8 * ofs);
            return j[127:0];
        end
        j64 = {b[63:0], a[63:0]} >> (8 * ofs);
        return {64'h0, j64[63:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic twrite(input int idx, input logic [127:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_idx = 5'(idx); tw_data = d;
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    task automatic rread(input int idx, output logic [127:0] d);
        rd_idx = 5'(idx);
        #1;
        d = rd_data;
    endtask

    // issues one instruction; returns with done/undef of that instruction visible
    task automatic issue(input logic [31:0] w);
        @(negedge clk);
        instr_valid = 1'b1; instr_word = w;
        @(negedge clk);
        instr_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [127:0] d;
        chk(!done && !undef, "R7 flags after reset", {done, undef}, 0);
        for (int i = 0; i < 32; i += 7) begin
            rread(i, d);
            chk(d == 0, "R7 register cleared", d, 0);
        end
    endtask

    task automatic t_preload;
        logic [127:0] d;
        for (int i = 0; i < 8; i++) twrite(i, pat(i));
        for (int i = 0; i < 8; i++) begin
            rread(i, d);
            chk(d == pat(i), "R8 test write/read", d, pat(i));
        end
    endtask

    task automatic t_wide;
        logic [127:0] d, e;
        for (int k = 0; k < 16; k++) begin
            issue(mk(1, 2, k, 1, 10));
            chk(done && !undef, "R6 done after wide", {done, undef}, 2);
            rread(10, d);
            e = model(1, k, pat(1), pat(2));
            chk(d == e, k == 0 ? "R4 wide offset 0" : "R2 wide window", d, e);
        end
    endtask

    task automatic t_narrow;
        logic [127:0] d, e;
        twrite(11, '1);
        for (int k = 0; k < 8; k++) begin
            issue(mk(0, 4, k, 3, 11));
            chk(done && !undef, "R6 done after narrow", {done, undef}, 2);
            rread(11, d);
            e = model(0, k, pat(3), pat(4));
            chk(d == e, k == 0 ? "R4 narrow offset 0" : "R3 narrow window", d, e);
        end
    endtask

    task automatic t_undef;
        logic [127:0] d;
        twrite(12, pat(12));
        for (int k = 8; k < 16; k += 3) begin
            issue(mk(0, 2, k, 1, 12));
            chk(undef && !done, "R5 undef flag", {done, undef}, 1);
            rread(12, d);
            chk(d == pat(12), "R5 no write on undef", d, pat(12));
        end
        @(negedge clk);
        chk(!undef, "R5 undef one cycle", undef, 0);
    endtask

    task automatic t_nomatch;
        logic [127:0] d;
        twrite(13, pat(13));
        issue(mk(1, 2, 3, 1, 13) | 32'h8000_0000);
        chk(!done && !undef, "R1 bit31 set ignored", {done, undef}, 0);
        issue(mk(1, 2, 3, 1, 13) | 32'h0000_0400);
        chk(!done && !undef, "R1 bit10 set ignored", {done, undef}, 0);
        rread(13, d);
        chk(d == pat(13), "R1 no write on mismatch", d, pat(13));
    endtask

    task automatic t_chain;
        logic [127:0] d, e1, e2;
        twrite(5, pat(5));
        twrite(6, pat(6));
        e1 = model(1, 4, pat(5), pat(6));
        e2 = model(1, 9, e1, pat(6));
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk(1, 6, 4, 5, 5);
        @(negedge clk);
        chk(done, "R11 first of pair done", done, 1);
        instr_word = mk(1, 6, 9, 5, 5);
        @(negedge clk);
        instr_valid = 1'b0;
        chk(done, "R11 second of pair done", done, 1);
        rread(5, d);
        chk(d == e2, "R9 in-place and back-to-back", d, e2);
        @(negedge clk);
        chk(!done, "R6 done one cycle", done, 0);
    endtask

    task automatic t_collide;
        logic [127:0] d, e;
        e = model(1, 7, pat(1), pat(2));
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk(1, 2, 7, 1, 20);
        tw_en = 1'b1; tw_idx = 5'd20; tw_data = pat(20);
        @(negedge clk);
        instr_valid = 1'b0; tw_en = 1'b0;
        rread(20, d);
        chk(d == e, "R10 instruction wins collision", d, e);
    endtask

    task automatic t_rereset;
        logic [127:0] d;
        @(negedge clk);
        instr_valid = 1'b1; instr_word = mk(1, 2, 1, 1, 21);
        rst = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0; rst = 1'b0;
        chk(!done, "R7 reset beats accept", done, 0);
        rread(1, d);
        chk(d == 0, "R7 mid-run clear", d, 0);
        rread(21, d);
        chk(d == 0, "R7 mid-run clear dest", d, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_preload();
        t_wide();
        t_narrow();
        t_undef();
        t_nomatch();
        t_chain();
        t_collide();
        t_rereset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule